// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block forms the digital tail of a pipelined analog-to-digital converter. The pipeline has eight redundant subconverter stages, each returning a 2-bit code, and a last 2-bit flash stage. The codes for one sample arrive one clock apart, from the first stage to the last. The block delays each stage code by its own number of clocks, so that all nine codes of a sample meet at one adder. There it merges the 18 raw bits into a single 10-bit word. Adjacent stages overlap by one bit, which corrects decision errors in the coarse stages.

The corrected word can be coded as offset binary or as two's complement, chosen by a format input. It then passes through two output registers, so the output is clocked in step with the sample clock. A valid flag tells downstream logic when the pipeline holds only samples taken after reset.

Top module: `adc_corr_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dataOut` is 0 and `dataValid` is 0.
- R2: For a sample whose stage-1 code is presented in cycle c, stage k's code is expected in cycle c+k-1 (the final flash stage in cycle c+8). The corrected word for that sample appears on `dataOut` in cycle c+10, which is two clocks after its final-stage code. Each following cycle delivers the next sample's word.
- R3: The offset-binary word is the sum of each redundant stage k's code (k = 1..8) weighted by 2^(9-k), plus the final-stage code with weight 1.
- R4: A redundant-stage code of binary 11 counts as binary 10. A final-stage code of 11 counts as 3.
- R5: The word saturates at 1023. All redundant stages at 10 or 11 with a final code of 11 give 1023.
- R6: With `fmtSel` = 0 the output is offset binary. With `fmtSel` = 1 the output has bit 9 inverted (two's complement). The `fmtSel` value that applies is the one present in the cycle of the sample's final-stage code.
- R7: After reset is released, `dataValid` stays 0 for 10 cycles. It then rises in the cycle that holds the first full sample's word and stays 1 every cycle until the next reset.
- R8: A reset asserted during operation drops `dataValid` and restarts the 10-cycle fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| fmtSel | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| stageCodes | input | 18 | Stage k's code on bits [2k-1:2k-2]; stage 9 (flash) on [17:16] |
| dataOut | output | 10 | Corrected output word |
| dataValid | output | 1 | High once the pipeline has filled after reset |

## Verification
The assertions take for granted that reset is held high from time zero through at least one clock edge. They also take for granted that `fmtSel` and every stage code are known values at each rising edge, because the format property compares the output with the corrected word and format seen two clocks earlier. The stimulus drives every input only on falling edges and always with defined values. It holds reset over several edges at the start of each phase. It sweeps all four code values on every stage, including 11 on redundant stages, and toggles `fmtSel` in runs, so that every format and saturation path is reached without unknown inputs.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int NUM_RED = 8;   // redundant stages
  localparam int CODE_W  = 2;
  localparam int OUT_W   = 10;

  typedef struct packed {
    logic flush;     // clear every pipeline register
    logic outValid;  // pipeline filled since last reset
  } ctrl_t;
endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (flush) begin
      for (int j = 0; j < DEPTH; j++) taps[j] <= '0;
    end else begin
      taps[0] <= din;
      for (int j = 1; j < DEPTH; j++) taps[j] <= taps[j-1];
    end
  end

  assign dout = taps[DEPTH-1];
endmodule

// File: rtl/adc_corr_ctrl.sv
module adc_corr_ctrl
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = NUM_RED
) (
  input  logic  clk,
  input  logic  rst,
  output ctrl_t ctrl
);
  localparam int FILL  = NUM_STAGES + 2;   // alignment plus two output registers
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (fillCnt != CNT_W'(FILL)) fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    ctrl.flush    = rst;
    ctrl.outValid = (fillCnt == CNT_W'(FILL));
  end
endmodule

// File: rtl/adc_corr_datapath.sv
module adc_corr_datapath
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = NUM_RED,
  parameter int CW         = CODE_W,
  parameter int OW         = OUT_W
) (
  input  logic                           clk,
  input  ctrl_t                          ctrl,
  input  logic                           fmtSel,
  input  logic [(NUM_STAGES+1)*CW-1:0]   stageCodes,
  output logic [OW-1:0]                  corrWord,
  output logic [OW-1:0]                  dataOut
);
  localparam int SUM_W   = OW + 1;
  localparam int MAX_RED = 2;   // largest legal redundant code

  logic [CW-1:0] aligned [NUM_STAGES+1];

  // stage k (index k-1) waits NUM_STAGES-(k-1) clocks; the flash stage is used directly
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_align
    adc_corr_delay #(.W(CW), .DEPTH(NUM_STAGES - k)) dly_i (
      .clk  (clk),
      .flush(ctrl.flush),
      .din  (stageCodes[k*CW +: CW]),
      .dout (aligned[k])
    );
  end
  assign aligned[NUM_STAGES] = stageCodes[NUM_STAGES*CW +: CW];

  logic [SUM_W-1:0] rawSum;

  always_comb begin
    rawSum = SUM_W'(aligned[NUM_STAGES]);
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (aligned[k] > CW'(MAX_RED))
        rawSum = rawSum + (SUM_W'(MAX_RED) << (NUM_STAGES - k));
      else
        rawSum = rawSum + (SUM_W'(aligned[k]) << (NUM_STAGES - k));
    end
  end

  assign corrWord = rawSum[SUM_W-1] ? {OW{1'b1}} : rawSum[OW-1:0];

  logic [OW-1:0] holdStage;

  always_ff @(posedge clk) begin
    if (ctrl.flush) begin
      holdStage <= '0;
      dataOut   <= '0;
    end else begin
      holdStage <= {corrWord[OW-1] ^ fmtSel, corrWord[OW-2:0]};
      dataOut   <= holdStage;
    end
  end
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = NUM_RED,
  parameter int CW         = CODE_W,
  parameter int OW         = OUT_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fmtSel,
  input  logic [(NUM_STAGES+1)*CW-1:0] stageCodes,
  output logic [OW-1:0]                dataOut,
  output logic                         dataValid
);
  ctrl_t         ctrl;
  logic [OW-1:0] corrWord;

  adc_corr_ctrl #(.NUM_STAGES(NUM_STAGES)) ctrl_i (
    .clk (clk),
    .rst (rst),
    .ctrl(ctrl)
  );

  adc_corr_datapath #(.NUM_STAGES(NUM_STAGES), .CW(CW), .OW(OW)) dp_i (
    .clk       (clk),
    .ctrl      (ctrl),
    .fmtSel    (fmtSel),
    .stageCodes(stageCodes),
    .corrWord  (corrWord),
    .dataOut   (dataOut)
  );

  assign dataValid = ctrl.outValid;
endmodule

// File: rtl/adc_corr_checker.sv
module adc_corr_checker #(
  parameter int NUM_STAGES = 8,
  parameter int OW         = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          fmtSel,
  input logic [OW-1:0] corrWord,
  input logic [OW-1:0] dataOut,
  input logic          dataValid
);
  localparam int FILL  = NUM_STAGES + 2;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != CNT_W'(FILL)) sinceRst <= sinceRst + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!dataValid && dataOut == '0)); // R1

  AST_FILL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < CNT_W'(FILL)) |-> !dataValid); // R7

  AST_FILL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == CNT_W'(FILL)) |-> dataValid); // R8

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> dataValid); // R7

  AST_FORMAT_MSB: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= CNT_W'(2)) |->
      (dataOut == ($past(corrWord, 2) ^ {$past(fmtSel, 2), {(OW-1){1'b0}}}))); // R6
endmodule

bind adc_corr_top adc_corr_checker #(.NUM_STAGES(NUM_STAGES), .OW(OW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .fmtSel   (fmtSel),
  .corrWord (corrWord),
  .dataOut  (dataOut),
  .dataValid(dataValid)
);

// File: tb/adc_corr_top_tb_top.sv
module adc_corr_top_tb_top;
  localparam int NC = 200;   // samples per phase

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmtSel = 1'b0;
  logic [17:0] stageCodes = '0;
  logic [9:0]  dataOut;
  logic        dataValid;

  always #5 clk = ~clk;

  adc_corr_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .fmtSel    (fmtSel),
    .stageCodes(stageCodes),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

  int codeArr [0:NC-1][1:9];
  int fmtArr  [0:NC+9];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic int expWord(int s, int f);
    int sum = codeArr[s][9];
    for (int k = 1; k <= 8; k++) begin
      int c = (codeArr[s][k] > 2) ? 2 : codeArr[s][k];
      sum += c * (1 << (9 - k));
    end
    if (sum > 1023) sum = 1023;
    if (f != 0) sum = sum ^ 512;
    return sum;
  endfunction

  function automatic string tagOf(int s, int f);
    int m = s % 40;
    if (m >= 4 && m < 8) return "R4 R5";
    if (f != 0) return "R6 R2";
    if (m >= 12 && m < 21) return "R3 R2";
    for (int k = 1; k <= 8; k++) if (codeArr[s][k] == 3) return "R4 R3";
    return "R3 R2";
  endfunction

  task automatic fillPhase(int p);
    for (int s = 0; s < NC; s++) begin
      int m = s % 40;
      for (int k = 1; k <= 9; k++) begin
        if (m < 4)                      codeArr[s][k] = 0;
        else if (m < 8)                 codeArr[s][k] = 3;
        else if (m < 12)                codeArr[s][k] = 2;
        else if (m < 21)                codeArr[s][k] = (k == m - 11) ? 1 + p : 0;
        else                            codeArr[s][k] = int'($urandom % 4);
      end
    end
    for (int t = 0; t <= NC + 9; t++) fmtArr[t] = ((t / 3) + p) % 2;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runPhase(int p);
    fillPhase(p);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int t = 0; t <= NC + 9; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 0) begin
        check(p == 0 ? "R1" : "R1 R8", int'(dataOut), 0);
        check(p == 0 ? "R1" : "R1 R8", int'(dataValid), 0);
      end else begin
        check(t < 10 ? "R7 R8" : "R7", int'(dataValid), (t >= 10) ? 1 : 0);
        if (t >= 10)
          check(tagOf(t - 10, fmtArr[t - 2]), int'(dataOut),
                expWord(t - 10, fmtArr[t - 2]));
      end
      rst    = 1'b0;
      fmtSel = fmtArr[t][0];
      for (int k = 1; k <= 9; k++) begin
        int s = t - k + 1;
        stageCodes[2*k-2 +: 2] = (s >= 0 && s < NC) ? 2'(codeArr[s][k]) : 2'b00;
      end
    end
  endtask

  initial begin
    runPhase(0);
    runPhase(1);   // mid-run reset, R8
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule